// File: doc/BRIEF.md
# I2C Serial Memory Slave Controller

This block is the digital front end of a byte-addressable nonvolatile memory attached to a two-wire I2C bus. The array itself is modelled with on-chip registers. SCL and SDA are oversampled by the system clock. Start and stop conditions are recovered from the sampled lines. The slave decodes a select byte against three strap inputs, keeps a word pointer that advances after every byte, and takes up to one page of data per write command in a 16-byte page buffer. That page is copied into the array only when a stop condition closes the command.

A copy into the array starts a busy window. Its length is a parameter, and it stands in for the internal programming time of a real cell array. During this window the slave refuses its select byte. A write-protect input blocks every copy into the array. Reads run sequentially for as long as the master acknowledges each byte. The slave drives SDA only as an open-drain pull-down enable. The array size is a parameter from 128 to 1024 bytes. The larger sizes take their upper address bits from select positions that no longer compare against the straps.

Top module: `i2cmem_slave`

## Requirements
- R1: While reset is active, and in the cycle after it, the SDA pull-down is off and the slave is not busy. Every array byte reads as 0x00 after reset.
- R2: The first byte after a start holds the code 1010 in bits 7..4, select bits in bits 3..1 and the read flag in bit 0, where 1 means read. The slave acknowledges only when the code matches and each select bit equals its strap (bit 3 to strap[2], bit 1 to strap[0]). A 512-byte array ignores bit 1 and a 1024-byte array ignores bits 2..1. On a mismatch the slave leaves SDA released until the next start or stop.
- R3: Bytes travel MSB first. After a write select byte, the second byte loads the word pointer, and each data byte after that is acknowledged and buffered. A later read returns the stored values. The SDA pull-down changes only in the cycle after a detected SCL falling edge, or after a start or stop.
- R4: Within one write command, the low 4 pointer bits wrap inside the current 16-byte page, and a later byte to the same offset replaces an earlier one.
- R5: In a read, the slave sends the byte at the pointer and then advances the pointer modulo the array size. It sends the next byte only if the master drove SDA low in the 9th clock.
- R6: A stop that commits data starts a busy window of WRITE_CYCLES clocks. While busy, the slave does not acknowledge a select byte. Once the window ends, it acknowledges again.
- R7: While the write-protect input is high at the stop, data bytes are still acknowledged but the array stays unchanged and no busy window starts.
- R8: After the master leaves the 9th clock of a read high (no acknowledge), the slave keeps SDA released for every further SCL pulse until a start or stop.
- R9: Buffered data is committed only by a stop that ends a command in its data phase. A repeated start discards the buffer. A stop after only the select byte or word byte changes nothing and starts no busy window.
- R10: For arrays above 256 bytes, the ignored select positions supply the pointer bits above bit 7 when the word byte is loaded (select bit 1 gives address bit 8, select bit 2 gives address bit 9).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | Pull SDA low when 1, release when 0 |
| strap | input | 3 | Device select straps |
| wp | input | 1 | Write protect, high blocks array updates |

## Verification
Most wrong states inside this block show up at SDA within one byte time. A pointer that is off by one, or that wraps at the wrong boundary, returns a wrong read byte in the same transfer. A bit counter that is off by one shifts the acknowledge into a data bit, so the master sees a missing or stray low in the 9th clock. Errors in the commit path stay hidden until the page is read back later. A bad busy timer shows as a refused or accepted select byte about one byte time after a stop. A write-protect or discard fault shows as a changed read value or as an unexpected busy refusal.

// File: rtl/i2cmem_pkg.sv
// Shared types for the I2C memory slave.
// Assumes: one state encoding for the byte engine in i2cmem_core.
package i2cmem_pkg;

    // Byte-engine phases of a bus command
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADDR,
        ST_WDATA,
        ST_RDATA,
        ST_WAIT
    } i2cmem_state_e;

    // Fixed upper nibble of the select byte
    localparam logic [3:0] DEV_CODE = 4'b1010;

endpackage

// File: rtl/i2cmem_sync.sv
// Synchronises SCL/SDA into the clock domain and derives edge and
// start/stop pulses. Assumes SCL high/low phases last several clocks.
module i2cmem_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_p, sda_p;
    logic              scl_s;

    // Metastability chains plus one-cycle history; bus idles high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_p  <= scl_sh[STAGES-1];
            sda_p  <= sda_sh[STAGES-1];
        end
    end

    // Edge and condition decode on the synchronised lines
    always_comb begin
        scl_s    = scl_sh[STAGES-1];
        sda_s    = sda_sh[STAGES-1];
        scl_rise = scl_s & ~scl_p;
        scl_fall = ~scl_s & scl_p;
        start_ev = scl_s & scl_p & sda_p & ~sda_s;
        stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/i2cmem_wtimer.sv
// Busy window after a commit. Assumes commit never arrives while busy.
module i2cmem_wtimer #(
    parameter int WRITE_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    output logic busy
);
    localparam int CW = $clog2(WRITE_CYCLES + 1);
    logic [CW-1:0] cnt_q;

    // Load on commit, count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (commit)         cnt_q <= CW'(WRITE_CYCLES);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/i2cmem_array.sv
// Register model of the memory array with a page-wide commit port.
// Assumes MEM_BYTES is a power of two and a multiple of PAGE_BYTES.
module i2cmem_array #(
    parameter int MEM_BYTES  = 128,
    parameter int PAGE_BYTES = 16,
    localparam int AW = $clog2(MEM_BYTES),
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit,
    input  logic [AW-1:0]           commit_base,
    input  logic [PAGE_BYTES*8-1:0] page_data,
    input  logic [PAGE_BYTES-1:0]   page_mask,
    input  logic [AW-1:0]           rd_addr,
    output logic [7:0]              rd_data
);
    logic [7:0] mem_q [MEM_BYTES];

    // Clear on reset; write all marked page bytes on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'h00;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (page_mask[i])
                    mem_q[{commit_base[AW-1:PW], i[PW-1:0]}] <= page_data[i*8 +: 8];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/i2cmem_core.sv
// Byte engine: select decode, pointer, page buffer, ack and read shifting.
// Assumes single-cycle event pulses from i2cmem_sync; start/stop win
// over clock edges in the same cycle.
module i2cmem_core
    import i2cmem_pkg::*;
#(
    parameter int MEM_BYTES  = 128,
    parameter int PAGE_BYTES = 16,
    localparam int AW      = $clog2(MEM_BYTES),
    localparam int PW      = $clog2(PAGE_BYTES),
    localparam int HI_BITS = (AW > 8) ? AW - 8 : 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_rise,
    input  logic                    scl_fall,
    input  logic                    sda_s,
    input  logic                    start_ev,
    input  logic                    stop_ev,
    input  logic [2:0]              strap,
    input  logic                    wp,
    input  logic                    busy,
    input  logic [7:0]              rd_data,
    output logic                    sda_oe,
    output logic [AW-1:0]           ptr,
    output logic                    commit,
    output logic [AW-1:0]           commit_base,
    output logic [PAGE_BYTES*8-1:0] page_data,
    output logic [PAGE_BYTES-1:0]   page_mask
);
    localparam logic [2:0] CMP_MASK = 3'b111 << HI_BITS;

    i2cmem_state_e   state_q;
    logic [3:0]      bitcnt_q;
    logic            in_ack_q, rnw_q, mack_q, oe_q, commit_q;
    logic [7:0]      shreg_q;
    logic [2:0]      sel_q;
    logic [AW-1:0]   ptr_q, base_q;
    logic [7:0]      pbuf_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvalid_q;
    logic            sel_match;
    logic [10:0]     waddr_full;

    // Select compare and full word address from select bits plus word byte
    always_comb begin
        sel_match  = (shreg_q[7:4] == DEV_CODE) &&
                     (((shreg_q[3:1] ^ strap) & CMP_MASK) == 3'b000);
        waddr_full = {sel_q, shreg_q};
    end

    // Bus command sequencing
    always_ff @(posedge clk) begin
        commit_q <= 1'b0;
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bitcnt_q <= '0;
            in_ack_q <= 1'b0;
            rnw_q    <= 1'b0;
            mack_q   <= 1'b0;
            oe_q     <= 1'b0;
            shreg_q  <= '0;
            sel_q    <= '0;
            ptr_q    <= '0;
            base_q   <= '0;
            pvalid_q <= '0;
        end else if (start_ev) begin
            state_q  <= ST_DEV;
            bitcnt_q <= '0;
            in_ack_q <= 1'b0;
            oe_q     <= 1'b0;
        end else if (stop_ev) begin
            if (state_q == ST_WDATA && (|pvalid_q) && !wp) commit_q <= 1'b1;
            base_q   <= ptr_q;
            state_q  <= ST_IDLE;
            in_ack_q <= 1'b0;
            oe_q     <= 1'b0;
        end else if (scl_rise) begin
            if (state_q inside {ST_DEV, ST_WADDR, ST_WDATA} && !in_ack_q && bitcnt_q != 4'd8) begin
                shreg_q  <= {shreg_q[6:0], sda_s};
                bitcnt_q <= bitcnt_q + 1'b1;
            end else if (state_q == ST_RDATA && !in_ack_q && bitcnt_q != 4'd8) begin
                bitcnt_q <= bitcnt_q + 1'b1;
            end else if (state_q == ST_RDATA && in_ack_q) begin
                mack_q <= !sda_s;
            end
        end else if (scl_fall) begin
            if (state_q inside {ST_DEV, ST_WADDR, ST_WDATA}) begin
                if (in_ack_q) begin
                    in_ack_q <= 1'b0;
                    bitcnt_q <= '0;
                    oe_q     <= 1'b0;
                    if (state_q == ST_DEV && rnw_q) begin
                        state_q <= ST_RDATA;
                        shreg_q <= rd_data;
                        oe_q    <= ~rd_data[7];
                    end else if (state_q == ST_DEV) begin
                        state_q <= ST_WADDR;
                    end else if (state_q == ST_WADDR) begin
                        state_q <= ST_WDATA;
                    end
                end else if (bitcnt_q == 4'd8) begin
                    in_ack_q <= 1'b1;
                    oe_q     <= 1'b1;
                    if (state_q == ST_DEV) begin
                        if (sel_match && !busy) begin
                            rnw_q <= shreg_q[0];
                            sel_q <= shreg_q[3:1];
                        end else begin
                            state_q  <= ST_WAIT;
                            in_ack_q <= 1'b0;
                            oe_q     <= 1'b0;
                        end
                    end else if (state_q == ST_WADDR) begin
                        ptr_q    <= waddr_full[AW-1:0];
                        pvalid_q <= '0;
                    end else begin
                        pbuf_q[ptr_q[PW-1:0]]   <= shreg_q;
                        pvalid_q[ptr_q[PW-1:0]] <= 1'b1;
                        ptr_q[PW-1:0]           <= ptr_q[PW-1:0] + 1'b1;
                    end
                end
            end else if (state_q == ST_RDATA) begin
                if (in_ack_q) begin
                    in_ack_q <= 1'b0;
                    bitcnt_q <= '0;
                    if (mack_q) begin
                        shreg_q <= rd_data;
                        oe_q    <= ~rd_data[7];
                    end else begin
                        state_q <= ST_WAIT;
                        oe_q    <= 1'b0;
                    end
                end else if (bitcnt_q == 4'd8) begin
                    in_ack_q <= 1'b1;
                    oe_q     <= 1'b0;
                    ptr_q    <= ptr_q + 1'b1;
                end else if (bitcnt_q != 4'd0) begin
                    shreg_q <= {shreg_q[6:0], 1'b0};
                    oe_q    <= ~shreg_q[6];
                end
            end
        end
    end

    // Flatten the page buffer for the array commit port
    always_comb begin
        for (int i = 0; i < PAGE_BYTES; i++) page_data[i*8 +: 8] = pbuf_q[i];
    end

    assign page_mask   = pvalid_q;
    assign sda_oe      = oe_q;
    assign ptr         = ptr_q;
    assign commit      = commit_q;
    assign commit_base = base_q;
endmodule

// File: rtl/i2cmem_slave.sv
// Top of the I2C memory slave: sync front end, byte engine, array and
// busy timer. Assumes clk runs at least 16 times faster than SCL.
module i2cmem_slave #(
    parameter int MEM_BYTES    = 128,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 2000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] strap,
    input  logic       wp
);
    localparam int AW = $clog2(MEM_BYTES);

    logic scl_rise, scl_fall, sda_s, start_ev, stop_ev;
    logic busy, commit;
    logic [AW-1:0] ptr, commit_base;
    logic [PAGE_BYTES*8-1:0] page_data;
    logic [PAGE_BYTES-1:0]   page_mask;
    logic [7:0] rd_data;

    i2cmem_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    i2cmem_core #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_core (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .start_ev(start_ev), .stop_ev(stop_ev),
        .strap(strap), .wp(wp), .busy(busy), .rd_data(rd_data),
        .sda_oe(sda_oe), .ptr(ptr), .commit(commit),
        .commit_base(commit_base), .page_data(page_data), .page_mask(page_mask)
    );

    i2cmem_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk(clk), .rst_n(rst_n), .commit(commit), .commit_base(commit_base),
        .page_data(page_data), .page_mask(page_mask),
        .rd_addr(ptr), .rd_data(rd_data)
    );

    i2cmem_wtimer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .commit(commit), .busy(busy)
    );
endmodule

// File: rtl/i2cmem_slave_checker.sv
// Protocol and commit-path properties for i2cmem_slave, bound below.
module i2cmem_slave_checker (
    input logic clk,
    input logic rst_n,
    input logic sda_oe,
    input logic scl_fall,
    input logic start_ev,
    input logic stop_ev,
    input logic commit,
    input logic busy,
    input logic wp
);
    // R1: pull-down off and idle through and right after reset
    a_r1_release_in_reset: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && !busy));

    // R3: SDA drive moves only after an SCL fall or a bus condition
    a_r3_sda_moves_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_ev) || $past(stop_ev)));

    // R6: a commit opens the busy window
    a_r6_commit_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy);

    // R6: no second commit inside a busy window
    a_r6_no_commit_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !busy);

    // R7: a commit needs write protect low at the closing stop
    a_r7_commit_needs_wp_low: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !$past(wp));
endmodule

bind i2cmem_slave i2cmem_slave_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .commit(commit),
    .busy(busy), .wp(wp)
);

// File: tb/test_i2cmem_slave.sv
// Bench: 512-byte array, straps 101, short busy window; a master model
// drives SCL/SDA and a byte model of the array predicts every read.
module test_i2cmem_slave;
    localparam int MEM  = 512;
    localparam int WCYC = 600;
    localparam int Q    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic [2:0] strap = 3'b101;
    logic sda_oe;
    logic sda_bus;
    logic [7:0] exp_mem [MEM];
    int n_chk = 0;
    int n_fail = 0;

    assign sda_bus = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    i2cmem_slave #(.MEM_BYTES(MEM), .WRITE_CYCLES(WCYC)) i_i2cmem_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .strap(strap), .wp(wp)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = !sda_bus; wq(); scl = 1'b0; wq();
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq(); scl = 1'b1; wq(); b[i] = sda_bus; wq(); scl = 1'b0; wq();
        end
        sda_m = give_ack ? 1'b0 : 1'b1; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] devb(input bit a8, input bit rd);
        return {4'b1010, strap[2], strap[1], a8, rd};
    endfunction

    // Write command of n bytes with values first+k; model follows R4/R7
    task automatic wr(input int addr, input int n, input logic [7:0] first, input bit wait_busy);
        bit a;
        logic [8:0] a9;
        a9 = addr[8:0];
        i2c_start();
        send_byte(devb(a9[8], 1'b0), a);
        check(a, "R2 select ack on write", a, 1);
        send_byte(a9[7:0], a);
        check(a, "R3 word byte ack", a, 1);
        for (int k = 0; k < n; k++) begin
            logic [7:0] v;
            logic [3:0] off;
            v = first + 8'(k);
            off = a9[3:0] + 4'(k);
            send_byte(v, a);
            check(a, wp ? "R7 data ack while protected" : "R3 data ack", a, 1);
            if (!wp) exp_mem[{a9[8:4], off}] = v;
        end
        i2c_stop();
        if (wait_busy) repeat (WCYC + 50) @(negedge clk);
    endtask

    // Random read of n bytes, checked against the model (R5 increment)
    task automatic rd(input int addr, input int n, input string tag);
        bit a;
        logic [7:0] b;
        logic [8:0] a9;
        a9 = addr[8:0];
        i2c_start();
        send_byte(devb(a9[8], 1'b0), a);
        send_byte(a9[7:0], a);
        i2c_start();
        send_byte(devb(a9[8], 1'b1), a);
        check(a, "R2 select ack on read", a, 1);
        for (int k = 0; k < n; k++) begin
            int ea;
            ea = (addr + k) % MEM;
            recv_byte(b, k != n - 1);
            check(b == exp_mem[ea], tag, b, exp_mem[ea]);
        end
        i2c_stop();
    endtask

    // Select byte alone, returns its acknowledge
    task automatic probe(input logic [7:0] dev, output bit ack);
        i2c_start();
        send_byte(dev, ack);
        i2c_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit a;
        logic [7:0] b;
        for (int i = 0; i < MEM; i++) exp_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        check(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(sda_oe == 1'b0, "R1 idle after reset", sda_oe, 0);

        // R2: sweep all select codes; strap[0] ignored at 512 bytes
        for (int c = 0; c < 8; c++) begin
            bit expa;
            expa = (c[2:1] == 2'b10);
            probe({4'b1010, c[2:0], 1'b0}, a);
            check(a == expa, "R2 select sweep", a, expa);
        end
        probe(8'hB8, a);
        check(a == 1'b0, "R2 wrong code", a, 0);
        rd(16'h000, 2, "R1 array zero after reset");

        // R3/R6/R10: byte write high half, refused while busy
        wr(16'h123, 1, 8'h5A, 1'b0);
        probe(devb(1'b0, 1'b0), a);
        check(a == 1'b0, "R6 no ack while busy", a, 0);
        repeat (WCYC + 50) @(negedge clk);
        probe(devb(1'b0, 1'b0), a);
        check(a == 1'b1, "R6 ack after window", a, 1);
        rd(16'h123, 1, "R3 byte readback");
        rd(16'h023, 1, "R10 low half untouched");

        // R4: 18 bytes from offset 14 wrap inside the page
        wr(16'h04E, 18, 8'h80, 1'b1);
        rd(16'h040, 17, "R4 page wrap");

        // R5: sequential read across the top of the array
        wr(16'h1FE, 2, 8'h11, 1'b1);
        wr(16'h000, 1, 8'h33, 1'b1);
        rd(16'h1FE, 4, "R5 sequential wrap");

        // R7: protected write leaves array unchanged, no busy window
        wp = 1'b1;
        wr(16'h123, 3, 8'hEE, 1'b0);
        probe(devb(1'b0, 1'b0), a);
        check(a == 1'b1, "R7 no busy when protected", a, 1);
        wp = 1'b0;
        rd(16'h123, 3, "R7 array unchanged");

        // R8: after a NACK the slave stays released for further clocks
        begin
            bit pulled;
            pulled = 1'b0;
            i2c_start();
            send_byte(devb(1'b0, 1'b0), a);
            send_byte(8'h40, a);
            i2c_start();
            send_byte(devb(1'b0, 1'b1), a);
            recv_byte(b, 1'b0);
            check(b == exp_mem[16'h040], "R5 read before NACK", b, exp_mem[16'h040]);
            for (int p = 0; p < 9; p++) begin
                wq(); scl = 1'b1; wq();
                if (!sda_bus) pulled = 1'b1;
                wq(); scl = 1'b0; wq();
            end
            check(pulled == 1'b0, "R8 released after NACK", pulled, 0);
            i2c_stop();
        end

        // R9: repeated start discards buffered data
        i2c_start();
        send_byte(devb(1'b0, 1'b0), a);
        send_byte(8'h60, a);
        send_byte(8'h77, a);
        i2c_start();
        send_byte(devb(1'b0, 1'b1), a);
        recv_byte(b, 1'b0);
        i2c_stop();
        probe(devb(1'b0, 1'b0), a);
        check(a == 1'b1, "R9 no commit after repeated start", a, 1);
        rd(16'h060, 1, "R9 discarded byte");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule